// File: doc/BRIEF.md
# Multi-Stage Reset Sequencer

This block turns one active-low external reset pin into the staged resets a small system-on-chip needs at power-up. When the pin goes low, four reset outputs assert at once and without waiting for any clock. When the pin goes high again, each output is released at its own time. A bus reset is released by counting in the bus clock domain. A clock-setup strobe, a cold reset and a hot reset are released one after another by counting in the core clock domain.

The pin's rising edge enters each clock domain through its own two-flop synchronizer before any counting starts. The clock-setup strobe counts CPU clock-enable pulses, which arrive as one-cycle ticks in the core domain. The cold reset counts plain core cycles from the synchronized release. The hot reset counts core cycles from the moment the cold reset is released. Pulling the pin low at any point clears every counter and re-asserts every output, and the next release starts the whole timing from the beginning.

Top module: `rst_stager`

## Requirements
- R1: While `ext_rst_n` is low, `bus_rst_o`=1, `clk_setup_o`=1, `cold_rst_n_o`=0 and `hot_rst_n_o`=0. A falling edge of `ext_rst_n` forces these values at once, with no clock edge needed.
- R2: `bus_rst_o` goes to 0 on the 6th `bus_clk` rising edge after `ext_rst_n` rises. That is 2 synchronizer edges followed by BUS_CYCLES=4 counting edges.
- R3: `clk_setup_o` goes to 0 on the core edge where the 2nd (SETUP_TICKS) `cpu_tick` is sampled high. Only core edges from the 3rd one after `ext_rst_n` rises are counted; ticks on the 1st and 2nd edges are ignored.
- R4: `cold_rst_n_o` goes to 1 on the 18th core edge after `ext_rst_n` rises (2 + COLD_CYCLES=16). If `clk_setup_o` falls on or after that edge, `cold_rst_n_o` goes to 1 on the edge after the one where `clk_setup_o` fell.
- R5: `hot_rst_n_o` goes to 1 on the 16th (HOT_CYCLES) core edge after the edge on which `cold_rst_n_o` rose.
- R6: The releases come in a fixed order, each on a strictly later core edge than the one before it: first `clk_setup_o` falls, then `cold_rst_n_o` rises, then `hot_rst_n_o` rises.
- R7: Once an output is released, it stays released until `ext_rst_n` falls again. The counters saturate and never wrap.
- R8: If `ext_rst_n` falls partway through the sequence, all outputs re-assert at once. The following release then repeats exactly the timing of R2 to R5, counted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_rst_n | input | 1 | External reset, active low; asserts asynchronously |
| bus_clk | input | 1 | Bus clock |
| core_clk | input | 1 | Core clock |
| cpu_tick | input | 1 | One-cycle CPU clock-enable pulse, core domain |
| bus_rst_o | output | 1 | Bus reset, active high |
| clk_setup_o | output | 1 | Clock-setup strobe, active high |
| cold_rst_n_o | output | 1 | Cold reset, active low |
| hot_rst_n_o | output | 1 | Hot reset, active low |

## Verification
The hardest cases to reach are those where the timing of one stage moves another. One is sparse `cpu_tick` pulses that push the clock-setup release onto or past the 18th core edge, so that the cold release has to wait. The other is a reset re-applied at an edge just before or just after a release. The bench sweeps every tick period from 1 to 16 with every phase, adds one very sparse pattern, and computes each expected release edge arithmetically. It then pulls the reset low on chosen edges: before synchronization, in the middle of the bus count, on the cold release edge, between cold and hot, and after hot. After each of these it runs a full sequence and checks that the timing is unchanged.

// File: rtl/rst_stager_pkg.sv
`timescale 1ns/1ps
package rst_stager_pkg;

    // Smallest counter width: every stage counter can hold at least 16.
    localparam int MIN_CNT_W = 5;

    // Clock domain indices used to pick a synchronizer.
    localparam int DOM_BUS  = 0;
    localparam int DOM_CORE = 1;
    localparam int NUM_DOM  = 2;

    // Release flags of the core-domain stages.
    typedef struct packed {
        logic setup_done;
        logic cold_done;
        logic hot_done;
    } core_flags_t;

    function automatic int cnt_width(input int count);
        int w;
        w = $clog2(count + 1);
        return (w > MIN_CNT_W) ? w : MIN_CNT_W;
    endfunction

endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: clears at once on arst_n low and releases after
// STAGES rising clock edges (STAGES must be 2 or more).
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_n
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], 1'b1};
        end
    end

    assign sync_n = pipe[STAGES-1];
endmodule

// File: rtl/rst_stage_cnt.sv
`timescale 1ns/1ps
// One release stage. While run is high, the stage counts the edges on which
// tick is high, up to COUNT, and then holds. done is set on the edge on which
// the count is (or becomes) COUNT while gate is high, and it stays set until
// arst_n clears it.
module rst_stage_cnt
    import rst_stager_pkg::*;
#(
    parameter int COUNT = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    input  logic tick,
    input  logic gate,
    output logic done
);
    localparam int W = cnt_width(COUNT);
    localparam logic [W-1:0] LIMIT = W'(COUNT);
    localparam logic [W-1:0] LAST  = W'(COUNT - 1);

    logic [W-1:0] cnt;
    logic         at_limit;
    logic         reaching;

    assign at_limit = (cnt == LIMIT);
    assign reaching = at_limit || (tick && (cnt == LAST));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (run && !done) begin
            if (tick && !at_limit) begin
                cnt <= cnt + 1'b1;
            end
            if (gate && reaching) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rst_stager.sv
`timescale 1ns/1ps
module rst_stager
    import rst_stager_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUS_CYCLES  = 4,
    parameter int SETUP_TICKS = 2,
    parameter int COLD_CYCLES = 16,
    parameter int HOT_CYCLES  = 16
) (
    input  logic ext_rst_n,
    input  logic bus_clk,
    input  logic core_clk,
    input  logic cpu_tick,
    output logic bus_rst_o,
    output logic clk_setup_o,
    output logic cold_rst_n_o,
    output logic hot_rst_n_o
);
    logic [NUM_DOM-1:0] dom_clk;
    logic [NUM_DOM-1:0] dom_rel;
    logic               bus_done;
    core_flags_t        flags;

    assign dom_clk[DOM_BUS]  = bus_clk;
    assign dom_clk[DOM_CORE] = core_clk;

    // One synchronizer for the release edge in each clock domain.
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_sync
        rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (dom_clk[d]),
            .arst_n (ext_rst_n),
            .sync_n (dom_rel[d])
        );
    end

    // Bus domain: plain cycle count after synchronized release.
    rst_stage_cnt #(.COUNT(BUS_CYCLES)) u_bus (
        .clk    (bus_clk),
        .arst_n (ext_rst_n),
        .run    (dom_rel[DOM_BUS]),
        .tick   (1'b1),
        .gate   (1'b1),
        .done   (bus_done)
    );

    // Core domain: clock-setup counts CPU enable ticks.
    rst_stage_cnt #(.COUNT(SETUP_TICKS)) u_setup (
        .clk    (core_clk),
        .arst_n (ext_rst_n),
        .run    (dom_rel[DOM_CORE]),
        .tick   (cpu_tick),
        .gate   (1'b1),
        .done   (flags.setup_done)
    );

    // Cold reset counts core cycles but may not release before clock setup.
    rst_stage_cnt #(.COUNT(COLD_CYCLES)) u_cold (
        .clk    (core_clk),
        .arst_n (ext_rst_n),
        .run    (dom_rel[DOM_CORE]),
        .tick   (1'b1),
        .gate   (flags.setup_done),
        .done   (flags.cold_done)
    );

    // Hot reset counts core cycles from the cold release.
    rst_stage_cnt #(.COUNT(HOT_CYCLES)) u_hot (
        .clk    (core_clk),
        .arst_n (ext_rst_n),
        .run    (flags.cold_done),
        .tick   (1'b1),
        .gate   (1'b1),
        .done   (flags.hot_done)
    );

    assign bus_rst_o    = ~bus_done;
    assign clk_setup_o  = ~flags.setup_done;
    assign cold_rst_n_o = flags.cold_done;
    assign hot_rst_n_o  = flags.hot_done;
endmodule

// File: rtl/rst_stager_chk.sv
`timescale 1ns/1ps
module rst_stager_chk #(
    parameter int HOT_CYCLES = 16
) (
    input logic ext_rst_n,
    input logic bus_clk,
    input logic core_clk,
    input logic bus_rst_o,
    input logic clk_setup_o,
    input logic cold_rst_n_o,
    input logic hot_rst_n_o
);
    // Core edges seen with the cold reset released, saturating.
    int cold_age;

    always_ff @(posedge core_clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            cold_age <= 0;
        end else if (cold_rst_n_o && cold_age < HOT_CYCLES) begin
            cold_age <= cold_age + 1;
        end
    end

    // R1
    core_held_chk: assert property (@(posedge core_clk)
        !ext_rst_n |-> (clk_setup_o && !cold_rst_n_o && !hot_rst_n_o));

    // R1
    bus_held_chk: assert property (@(posedge bus_clk)
        !ext_rst_n |-> bus_rst_o);

    // R6
    cold_after_setup_chk: assert property (@(posedge core_clk) disable iff (!ext_rst_n)
        cold_rst_n_o |-> !clk_setup_o);

    // R6
    hot_after_cold_chk: assert property (@(posedge core_clk) disable iff (!ext_rst_n)
        hot_rst_n_o |-> cold_rst_n_o);

    // R7
    cold_sticky_chk: assert property (@(posedge core_clk) disable iff (!ext_rst_n)
        cold_rst_n_o |=> cold_rst_n_o);

    // R7
    bus_sticky_chk: assert property (@(posedge bus_clk) disable iff (!ext_rst_n)
        !bus_rst_o |=> !bus_rst_o);

    // R5
    hot_gap_chk: assert property (@(posedge core_clk) disable iff (!ext_rst_n)
        hot_rst_n_o == (cold_age >= HOT_CYCLES));
endmodule

bind rst_stager rst_stager_chk #(.HOT_CYCLES(HOT_CYCLES)) u_chk (.*);

// File: tb/test_rst_stager.sv
`timescale 1ns/1ps
module test_rst_stager;
    localparam int SYNC   = 2;
    localparam int BUSN   = 4;
    localparam int SETUPN = 2;
    localparam int COLDN  = 16;
    localparam int HOTN   = 16;
    localparam int TAIL   = 30;

    logic ext_rst_n = 1'b1;
    logic bus_clk   = 1'b0;
    logic core_clk  = 1'b0;
    logic cpu_tick  = 1'b0;
    logic bus_rst_o, clk_setup_o, cold_rst_n_o, hot_rst_n_o;

    int checks = 0;
    int errors = 0;
    bit aborted;

    always #5   core_clk = ~core_clk;
    always #7.3 bus_clk  = ~bus_clk;

    rst_stager i_rst_stager (
        .ext_rst_n    (ext_rst_n),
        .bus_clk      (bus_clk),
        .core_clk     (core_clk),
        .cpu_tick     (cpu_tick),
        .bus_rst_o    (bus_rst_o),
        .clk_setup_o  (clk_setup_o),
        .cold_rst_n_o (cold_rst_n_o),
        .hot_rst_n_o  (hot_rst_n_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int outs();
        return int'({bus_rst_o, clk_setup_o, cold_rst_n_o, hot_rst_n_o});
    endfunction

    // Edge index of the SETUPN-th counted tick (R3).
    function automatic int exp_setup(input int per, input int ph);
        int n = 0;
        for (int k = SYNC + 1; k < 1000; k++) begin
            if ((k % per) == ph) begin
                n++;
                if (n == SETUPN) return k;
            end
        end
        return -1;
    endfunction

    task automatic run_seq(input int per, input int ph, input int abort_k, input string ctx);
        int s_exp = exp_setup(per, ph);
        int c_exp = (s_exp + 1 > SYNC + COLDN) ? s_exp + 1 : SYNC + COLDN;
        int h_exp = c_exp + HOTN;
        int limit = (abort_k > 0) ? abort_k : h_exp + TAIL;
        int s_rel = -1, c_rel = -1, h_rel = -1, b_rel = -1;
        bit stick_bad = 0, ord_bad = 0;

        @(negedge core_clk);
        // R1: held while the pin is low
        chk(outs() == 4'b1100, "R1", {ctx, " held in reset"}, outs(), 4'b1100);
        #2 ext_rst_n = 1'b1;
        aborted = 1'b0;
        fork
            begin
                int b = 0;
                while (!aborted && b_rel < 0 && b < 100) begin
                    @(posedge bus_clk);
                    b++;
                    #1;
                    if (!bus_rst_o && !aborted) b_rel = b;
                end
            end
            begin
                for (int k = 1; k <= limit; k++) begin
                    cpu_tick = ((k % per) == ph);
                    @(posedge core_clk);
                    #1;
                    if (!clk_setup_o  && s_rel < 0) s_rel = k;
                    if (cold_rst_n_o  && c_rel < 0) c_rel = k;
                    if (hot_rst_n_o   && h_rel < 0) h_rel = k;
                    if ((s_rel >= 0 && clk_setup_o) || (c_rel >= 0 && !cold_rst_n_o) ||
                        (h_rel >= 0 && !hot_rst_n_o)) stick_bad = 1'b1;
                    if ((cold_rst_n_o && clk_setup_o) || (hot_rst_n_o && !cold_rst_n_o))
                        ord_bad = 1'b1;
                    if (k == abort_k) begin
                        #2 ext_rst_n = 1'b0;
                        aborted = 1'b1;
                        #1;
                        // R8: immediate re-assertion mid-sequence
                        chk(outs() == 4'b1100, "R8", {ctx, " re-assert"}, outs(), 4'b1100);
                        break;
                    end
                    @(negedge core_clk);
                end
                cpu_tick = 1'b0;
            end
        join
        if (!aborted) begin
            chk(b_rel == SYNC + BUSN, "R2", {ctx, " bus release edge"}, b_rel, SYNC + BUSN);
            chk(s_rel == s_exp, "R3", {ctx, " setup release edge"}, s_rel, s_exp);
            chk(c_rel == c_exp, "R4", {ctx, " cold release edge"}, c_rel, c_exp);
            chk(h_rel == h_exp, "R5", {ctx, " hot release edge"}, h_rel, h_exp);
            chk(!ord_bad && s_rel < c_rel && c_rel < h_rel, "R6", {ctx, " release order"},
                int'(ord_bad), 0);
            chk(!stick_bad, "R7", {ctx, " released outputs stay released"}, int'(stick_bad), 0);
            @(negedge core_clk);
            #2 ext_rst_n = 1'b0;
            #1;
            // R1: asynchronous assertion between clock edges
            chk(outs() == 4'b1100, "R1", {ctx, " async assert"}, outs(), 4'b1100);
        end
        repeat (3) @(posedge core_clk);
    endtask

    int ab_per[7] = '{3, 1, 2, 5, 2, 4, 7};
    int ab_ph [7] = '{0, 0, 0, 1, 0, 2, 3};
    int ab_k  [7] = '{1, 2, 4, 17, 18, 25, 40};

    initial begin
        #3 ext_rst_n = 1'b0;
        repeat (4) @(posedge core_clk);
        for (int per = 1; per <= 16; per++) begin
            for (int ph = 0; ph < per; ph++) begin
                run_seq(per, ph, 0, "sweep");
            end
        end
        run_seq(25, 24, 0, "sparse ticks");
        for (int i = 0; i < 7; i++) begin
            run_seq(ab_per[i], ab_ph[i], ab_k[i], "abort");
            run_seq(ab_per[i], ab_ph[i], 0, "R8 restart");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule